// File: doc/BRIEF.md
# Eight-Bit Event Timer with Power-of-Two Prescaler

This block keeps an 8-bit count that advances on events from one of two sources: an internal strobe that pulses once per instruction cycle, or an external clock pin. The pin is brought into the clock domain through a two-flop synchronizer. Either its rising or its falling transitions are then counted. A prescaler can sit between the chosen source and the counter and divide the event rate by a power of two from 2 to 256. It can also be bypassed, so that every source event advances the count.

Software reads the count at any time and may overwrite it. An overwrite restarts the prescaler and suppresses counting briefly, so a freshly written value is not disturbed. When the count passes from FFh to 00h, a sticky overflow flag is raised for the interrupt controller. The flag stays set until that controller clears it. All configuration comes from a packed 6-bit option input. There is no streaming data path, so every pin is a plain level or single-cycle pulse.

Top module: `rtc_timer8`

## Requirements
- R1: While reset is asserted and after its release, the count reads 00h and the overflow flag is 0.
- R2: A cycle with `wr_en`=1 loads `wr_data` into the count, visible on `count_q` after that clock edge, regardless of any event in the same cycle.
- R3: With `opt_cfg[3]`=1 (prescaler bypassed) and `opt_cfg[5]`=0 (internal source), the count rises by one for each cycle in which `cyc_strobe` is 1.
- R4: With `opt_cfg[3]`=0, the count rises by one per 2^(`opt_cfg[2:0]`+1) source events, from 1:2 at code 0 to 1:256 at code 7.
- R5: With `opt_cfg[5]`=1 and `opt_cfg[4]`=0, each low-to-high transition on `ext_clk_pin` is one source event, and `cyc_strobe` has no effect.
- R6: With `opt_cfg[5]`=1 and `opt_cfg[4]`=1, each high-to-low transition on `ext_clk_pin` is one source event, and rising transitions are not counted.
- R7: An advance from FFh wraps the count to 00h and sets `ovf_flag`, which then stays set.
- R8: `ovf_clr`=1 clears `ovf_flag` at the next edge, unless a wrap occurs in the same cycle, in which case the flag remains set.
- R9: A count write restarts the prescaler from zero and discards source events in the write cycle and in the two cycles after it.
- R10: With `opt_cfg[5]`=0, transitions on `ext_clk_pin` do not change the count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | Instruction-cycle event pulse (internal source) |
| ext_clk_pin | input | 1 | Asynchronous external count pin |
| opt_cfg | input | 6 | [5] source select (1 = pin), [4] pin edge (1 = falling), [3] prescaler bypass, [2:0] ratio code |
| wr_en | input | 1 | Count write strobe |
| wr_data | input | 8 | Value to load into the count |
| count_q | output | 8 | Current count |
| ovf_flag | output | 1 | Sticky overflow flag |
| ovf_clr | input | 1 | Clears the overflow flag |

## Verification
Assertions watch several rules on every cycle. A write lands exactly on the next edge, and the count holds steady in the cycle after a write. A bypassed prescaler stays frozen. The prescaler is zero after a restart. A rising flag coincides with a count of zero. Each synchronized edge event matches the pin history three clocks back. The exact division ratios, the counting of the chosen pin edge, the three-cycle event blackout around a write, and the precedence of a wrap over a clear only show up as totals across whole scenarios. The bench therefore checks those against its own model of the requirements, under directed and random stimulus.

// File: rtl/rtc_timer8_pkg.sv
package rtc_timer8_pkg;

  localparam int unsigned RATIO_W = 3;

  typedef struct packed {
    logic               src_ext;    // 1: count external pin events
    logic               edge_fall;  // 1: falling edge of pin
    logic               pre_bypass; // 1: prescaler not in path
    logic [RATIO_W-1:0] ratio;      // divide by 2^(ratio+1)
  } tmr_opt_t;

  localparam int unsigned OPT_W = $bits(tmr_opt_t);

endpackage

// File: rtl/rtc_edge_sync.sv
module rtc_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_i,
  output logic rise_o,
  output logic fall_o
);
  localparam int unsigned HW = STAGES + 1;

  logic [HW-1:0] shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) shreg <= '0;
    else        shreg <= {shreg[HW-2:0], pin_i};
  end

  assign rise_o =  shreg[HW-2] & ~shreg[HW-1];
  assign fall_o = ~shreg[HW-2] &  shreg[HW-1];

  // Warm-up counter so the history check never reaches before reset.
  logic [3:0] warm;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     warm <= '0;
    else if (warm < 4'(STAGES + 2)) warm <= warm + 4'd1;
  end

  generate
    if (STAGES == 2) begin : g_chk2
      assert_rise_hist_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 4'(STAGES + 2) && rise_o) |-> ($past(pin_i, 2) && !$past(pin_i, 3)));
      assert_fall_hist_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (warm == 4'(STAGES + 2) && fall_o) |-> (!$past(pin_i, 2) && $past(pin_i, 3)));
    end
  endgenerate

endmodule

// File: rtl/rtc_prescaler.sv
module rtc_prescaler #(
  parameter int unsigned RATIO_W = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               evt_i,
  input  logic               bypass_i,
  input  logic [RATIO_W-1:0] ratio_i,
  output logic               tick_o
);
  localparam int unsigned PRE_W = 1 << RATIO_W;

  logic [PRE_W-1:0] pre_cnt;
  logic [PRE_W-1:0] tap_mask;

  // Bits 0..ratio must all be ones for the final event of a period.
  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      tap_mask[i] = (i <= int'(ratio_i));
    end
  end

  logic period_end;
  assign period_end = ((pre_cnt & tap_mask) == tap_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   pre_cnt <= '0;
    else if (clr_i)               pre_cnt <= '0;
    else if (!bypass_i && evt_i)  pre_cnt <= pre_cnt + 1'b1;
  end

  assign tick_o = evt_i & (bypass_i | period_end);

  assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
    clr_i |=> (pre_cnt == '0));

  assert_idle_bypass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bypass_i && !clr_i) |=> $stable(pre_cnt));

endmodule

// File: rtl/rtc_count_reg.sv
module rtc_count_reg #(
  parameter int unsigned CW      = 8,
  parameter int unsigned HOLD_CY = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_i,
  input  logic [CW-1:0] wdata_i,
  input  logic          tick_i,
  input  logic          flag_clr_i,
  output logic [CW-1:0] cnt_o,
  output logic          flag_o,
  output logic          hold_o
);
  localparam int unsigned HW = $clog2(HOLD_CY + 1);

  logic [HW-1:0] hold_q;
  logic          adv;
  logic          wrap;

  assign hold_o = (hold_q != '0);
  assign adv    = tick_i & ~wr_i & ~hold_o;
  assign wrap   = adv & (cnt_o == {CW{1'b1}});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_o  <= '0;
      hold_q <= '0;
    end else if (wr_i) begin
      cnt_o  <= wdata_i;
      hold_q <= HW'(HOLD_CY);
    end else begin
      if (hold_o) hold_q <= hold_q - 1'b1;
      if (adv)    cnt_o  <= cnt_o + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          flag_o <= 1'b0;
    else if (wrap)       flag_o <= 1'b1;
    else if (flag_clr_i) flag_o <= 1'b0;
  end

  logic armed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_i |=> (cnt_o == $past(wdata_i)));

  assert_hold_after_wr_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $past(wr_i) && !wr_i) |=> (cnt_o == $past(cnt_o)));

  assert_flag_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && $rose(flag_o)) |-> (cnt_o == '0));

  assert_flag_keep_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_o && !flag_clr_i) |=> flag_o);

endmodule

// File: rtl/rtc_timer8.sv
module rtc_timer8
  import rtc_timer8_pkg::*;
#(
  parameter int unsigned CNT_W       = 8,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned WR_HOLD     = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cyc_strobe,
  input  logic             ext_clk_pin,
  input  logic [OPT_W-1:0] opt_cfg,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] count_q,
  output logic             ovf_flag,
  input  logic             ovf_clr
);
  tmr_opt_t opt;
  assign opt = tmr_opt_t'(opt_cfg);

  logic pin_rise, pin_fall, pin_evt;
  logic src_evt, gated_evt, pre_tick, hold;

  rtc_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .pin_i  (ext_clk_pin),
    .rise_o (pin_rise),
    .fall_o (pin_fall)
  );

  assign pin_evt   = opt.edge_fall ? pin_fall : pin_rise;
  assign src_evt   = opt.src_ext ? pin_evt : cyc_strobe;
  assign gated_evt = src_evt & ~hold & ~wr_en;

  rtc_prescaler #(.RATIO_W(RATIO_W)) u_pre (
    .clk      (clk),
    .rst_n    (rst_n),
    .clr_i    (wr_en),
    .evt_i    (gated_evt),
    .bypass_i (opt.pre_bypass),
    .ratio_i  (opt.ratio),
    .tick_o   (pre_tick)
  );

  rtc_count_reg #(.CW(CNT_W), .HOLD_CY(WR_HOLD)) u_cnt (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_i       (wr_en),
    .wdata_i    (wr_data),
    .tick_i     (pre_tick),
    .flag_clr_i (ovf_clr),
    .cnt_o      (count_q),
    .flag_o     (ovf_flag),
    .hold_o     (hold)
  );

  assert_no_tick_in_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hold |-> !pre_tick);

  assert_pin_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!opt.src_ext && !cyc_strobe && !wr_en) |=> $stable(count_q));

endmodule

// File: tb/sim_rtc_timer8.sv
module sim_rtc_timer8;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_strobe = 1'b0;
  logic       ext_clk_pin = 1'b0;
  logic [5:0] opt_cfg = 6'h08;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] count_q;
  logic       ovf_flag;
  logic       ovf_clr = 1'b0;

  always #10 clk = ~clk; // 50 MHz

  rtc_timer8 u0 (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .ext_clk_pin(ext_clk_pin),
    .opt_cfg(opt_cfg), .wr_en(wr_en), .wr_data(wr_data), .count_q(count_q),
    .ovf_flag(ovf_flag), .ovf_clr(ovf_clr)
  );

  int checks = 0;
  int failures = 0;
  string cur_req = "R1";
  bit finished = 1'b0;

  // Reference model built from the requirements.
  logic [7:0] m_cnt;
  logic       m_flag;
  int         m_pre;
  int         m_blk;
  logic       p1, p2, p3;

  function automatic bit src_event(logic [5:0] o, logic s, logic a, logic b);
    if (!o[5]) return s;
    if (o[4])  return (!a && b);
    return (a && !b);
  endfunction

  function automatic int period_of(logic [2:0] code);
    return 2 << code;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cnt = 8'h00; m_flag = 1'b0; m_pre = 0; m_blk = 0;
      p1 = 1'b0; p2 = 1'b0; p3 = 1'b0;
    end else begin
      bit ev, adv, wrapped;
      ev = src_event(opt_cfg, cyc_strobe, p2, p3);
      adv = 1'b0; wrapped = 1'b0;
      if (wr_en) begin
        m_cnt = wr_data; m_pre = 0; m_blk = 2;
      end else if (m_blk > 0) begin
        m_blk = m_blk - 1;
      end else if (ev) begin
        if (opt_cfg[3]) adv = 1'b1;
        else begin
          m_pre = (m_pre + 1) % 256;
          adv = ((m_pre % period_of(opt_cfg[2:0])) == 0);
        end
      end
      if (adv) begin
        wrapped = (m_cnt == 8'hFF);
        m_cnt = m_cnt + 8'h01;
      end
      if (wrapped) m_flag = 1'b1;
      else if (ovf_clr) m_flag = 1'b0;
      p3 = p2; p2 = p1; p1 = ext_clk_pin;
    end
  end

  task automatic check(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic model_cmp();
    check(count_q == m_cnt, cur_req, "count vs model", count_q, m_cnt);
    check(ovf_flag == m_flag, cur_req, "flag vs model", ovf_flag, m_flag);
  endtask

  task automatic step(logic s, logic p, logic w, logic [7:0] d, logic c);
    @(negedge clk);
    model_cmp();
    cyc_strobe = s; ext_clk_pin = p; wr_en = w; wr_data = d; ovf_clr = c;
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, ext_clk_pin, 1'b0, 8'h00, 1'b0);
  endtask

  task automatic load(logic [7:0] v);
    step(1'b0, ext_clk_pin, 1'b1, v, 1'b0);
    idle(3);
  endtask

  task automatic expect_now(string req, int exp_cnt, int exp_flag);
    @(negedge clk);
    check(count_q == exp_cnt[7:0], req, "count", count_q, exp_cnt);
    check(ovf_flag == exp_flag[0], req, "flag", ovf_flag, exp_flag);
    cyc_strobe = 1'b0; wr_en = 1'b0; ovf_clr = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++; checks++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    cur_req = "R1";
    check(count_q == 8'h00, "R1", "count in reset", count_q, 0);
    check(ovf_flag == 1'b0, "R1", "flag in reset", ovf_flag, 0);
    rst_n = 1'b1;
    expect_now("R1", 0, 0);

    // R2: write lands next edge even with a strobe present
    cur_req = "R2";
    opt_cfg = 6'b001000;
    step(1'b1, 1'b0, 1'b1, 8'h5A, 1'b0);
    expect_now("R2", 8'h5A, 0);

    // R3: bypassed, internal strobe
    cur_req = "R3";
    load(8'h10);
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(1);
    expect_now("R3", 8'h24, 0);

    // R4: ratios 1:4 and 1:256
    cur_req = "R4";
    opt_cfg = 6'b000001;
    load(8'h00);
    for (int i = 0; i < 64; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(1);
    expect_now("R4", 16, 0);
    opt_cfg = 6'b000111;
    load(8'h00);
    for (int i = 0; i < 512; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(1);
    expect_now("R4", 2, 0);

    // R5: rising pin edges, strobe held high and ignored
    cur_req = "R5";
    opt_cfg = 6'b101000;
    load(8'h00);
    for (int k = 0; k < 10; k++) begin
      step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
      step(1'b1, 1'b1, 1'b0, 8'h00, 1'b0);
      step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
      step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    end
    idle(4);
    expect_now("R5", 10, 0);

    // R6: falling edges; pin starts low, ends high so 6 falls precede
    cur_req = "R6";
    opt_cfg = 6'b111000;
    load(8'h00);
    for (int k = 0; k < 6; k++) begin
      step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
      step(1'b0, 1'b0, 1'b0, 8'h00, 1'b0);
    end
    step(1'b0, 1'b1, 1'b0, 8'h00, 1'b0);
    idle(5);
    expect_now("R6", 6, 0);

    // R7: wrap sets the sticky flag
    cur_req = "R7";
    opt_cfg = 6'b001000;
    ext_clk_pin = 1'b0;
    load(8'hFE);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(3);
    expect_now("R7", 8'h00, 1);

    // R8: clear, then wrap and clear together
    cur_req = "R8";
    step(1'b0, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_now("R8", 8'h00, 0);
    load(8'hFF);
    step(1'b1, 1'b0, 1'b0, 8'h00, 1'b1);
    expect_now("R8", 8'h00, 1);

    // R9: three-cycle blackout, then strobes count
    cur_req = "R9";
    step(1'b1, 1'b0, 1'b1, 8'h00, 1'b1);
    for (int i = 0; i < 7; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    expect_now("R9", 5, 0);
    // prescaler restart: 1:4, 3 events, write, then 4 events -> exactly 1
    opt_cfg = 6'b000001;
    load(8'h00);
    for (int i = 0; i < 3; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    load(8'h40);
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 8'h00, 1'b0);
    idle(1);
    expect_now("R9", 8'h41, 0);

    // R10: internal source ignores pin toggles
    cur_req = "R10";
    opt_cfg = 6'b001000;
    load(8'h33);
    for (int i = 0; i < 30; i++) step(1'b0, i[1], 1'b0, 8'h00, 1'b0);
    expect_now("R10", 8'h33, 0);

    // Random mix against the model
    cur_req = "R4";
    for (int i = 0; i < 6000; i++) begin
      if (i % 150 == 0) opt_cfg = 6'($urandom);
      if (opt_cfg[5]) cur_req = opt_cfg[4] ? "R6" : "R5";
      else cur_req = opt_cfg[3] ? "R3" : "R4";
      step(1'($urandom % 2),
           ($urandom % 3 == 0) ? ~ext_clk_pin : ext_clk_pin,
           ($urandom % 64 == 0), 8'($urandom),
           ($urandom % 40 == 0));
    end
    idle(2);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule